// File: doc/BRIEF.md
# Channel Status Transmit Sequencer

This block supplies the channel-status bit for every frame that a serial digital audio transmitter sends. A host fills a page of six 32-bit words through a simple write port. Together the six words hold one 192-frame channel-status block. The transmitter asks for each subframe with a request pulse, and a marker tells the block whether the request opens a new frame. On each frame-opening request the sequencer produces the next channel-status bit and holds it for both subframes of that frame. It also raises a block-start select, which the transmitter uses to choose its B preamble.

The page is walked from the least significant bit of word 0 up through word 5. After word 5 the walk returns to word 0. Each word is copied into an internal shifter at the moment its first bit is due. A host write therefore lands at the next word boundary and never in the middle of a word.

Two busy flags report the state of the block. The first tracks the transmitter as a whole. The second tracks the part of the block during which channel status is being shifted out. The biphase encoder and the audio sample path sit outside this block.

Top module: `cstx_seq`

## Requirements
- R1: The page has six 32-bit words, selected by wr_addr values 0 to 5 when wr_en is 1. Writes with wr_addr 6 or 7 change no word. Reset clears every word to 0.
- R2: Frame n of a block (n counted from 0 to 191) carries bit n mod 32 of word n div 32. After frame 191 the next frame is frame 0 of a new block.
- R3: A frame-start request is sub_req=1 with sub_first=1. It updates c_bit and blk_start on the clock edge that accepts it. A second-subframe request is sub_req=1 with sub_first=0; with tx_en and cs_en high it leaves c_bit unchanged.
- R4: blk_start is 1 for frame 0 of every block and 0 for every other frame.
- R5: A word is copied into the shifter when its bit 0 is due. A write to the word being sent affects only the next block. A write to a later word, made before its bit 0 is due, is used in the current block.
- R6: cs_busy goes to 1 when word 0 is loaded with tx_en and cs_en both high. It goes to 0 when word 5 is loaded, so it is 1 after frames 0 to 159 and 0 after frames 160 to 191.
- R7: tx_busy is 1 from the edge after tx_en is sampled high. A second-subframe request accepted while tx_en is low ends the frame. On that edge tx_busy, cs_busy, c_bit and blk_start go to 0, and the position returns to frame 0.
- R8: Frame-start requests with tx_en low do not advance the position. The first frame after tx_en returns is frame 0.
- R9: On the edge after cs_en is sampled low, c_bit, blk_start and cs_busy are 0 and the position is frame 0. tx_busy is not affected.
- R10: After reset c_bit, blk_start, cs_busy and tx_busy are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmitter enable |
| cs_en | input | 1 | Channel-status insertion enable |
| sub_req | input | 1 | Subframe request pulse from the transmitter |
| sub_first | input | 1 | Marks a request as the first subframe of a frame |
| wr_en | input | 1 | Page write strobe |
| wr_addr | input | 3 | Page word index |
| wr_data | input | 32 | Page write data |
| c_bit | output | 1 | Channel-status bit for the current frame |
| blk_start | output | 1 | Block-start select (B preamble) for the current frame |
| cs_busy | output | 1 | Channel-status shifting busy |
| tx_busy | output | 1 | Transmitter busy |

## Verification
The bench runs two whole blocks and checks every frame against a bit position computed from the frame number. It also checks that the second block wraps to word 0. A sequencer that read the live page instead of a per-word copy fails the mid-word write case: there the rest of word 1 must still come from the old value, while word 2 must already use the new one. Other cases aim at the busy edges at frames 0 and 160, at the frame-end stop after tx_en drops, and at the restart from frame 0 after either enable returns. A design that cleared a flag one frame early, or that advanced the position while stopped, would show the wrong bit or a missing block-start select.

// File: rtl/cstx_pkg.sv
package cstx_pkg;

    localparam int CS_WORD_W = 32;
    localparam int CS_WORDS  = 6;

    typedef enum logic [1:0] {
        EV_NONE  = 2'd0,
        EV_START = 2'd1,
        EV_SECOND = 2'd2
    } frame_ev_e;

    typedef struct packed {
        logic c;
        logic blk;
        logic load_first;
        logic load_last;
    } cs_step_t;

    function automatic frame_ev_e ev_decode(input logic req, input logic first);
        if (!req)
            return EV_NONE;
        return first ? EV_START : EV_SECOND;
    endfunction

endpackage

// File: rtl/cstx_page.sv
module cstx_page #(
    parameter int WORD_W = 32,
    parameter int WORDS  = 6,
    localparam int WAW   = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WAW-1:0]    wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [WAW-1:0]    rd_idx,
    output logic [WORD_W-1:0] rd_word
);

    logic [WORD_W-1:0] mem [WORDS];
    logic [WORDS-1:0]  we;

    for (genvar g = 0; g < WORDS; g++) begin : g_we
        assign we[g] = wr_en && (wr_addr == WAW'(g));
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < WORDS; i++) begin
            if (rst)
                mem[i] <= '0;
            else if (we[i])
                mem[i] <= wr_data;
        end
    end

    always_comb begin
        rd_word = '0;
        for (int i = 0; i < WORDS; i++)
            if (rd_idx == WAW'(i))
                rd_word = mem[i];
    end

endmodule

// File: rtl/cstx_cursor.sv
module cstx_cursor
    import cstx_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int WORDS  = 6,
    localparam int WAW   = (WORDS > 1) ? $clog2(WORDS) : 1,
    localparam int BW    = (WORD_W > 1) ? $clog2(WORD_W) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  frame_ev_e         ev,
    input  logic              tx_en,
    input  logic              cs_en,
    input  logic [WORD_W-1:0] rd_word,
    output logic [WAW-1:0]    rd_idx,
    output cs_step_t          step
);

    localparam logic [BW-1:0]  BIT_LAST  = BW'(WORD_W - 1);
    localparam logic [WAW-1:0] WORD_LAST = WAW'(WORDS - 1);

    logic [BW-1:0]     bit_q;
    logic [WAW-1:0]    word_q;
    logic [WORD_W-1:0] sh_q;
    logic              c_q, blk_q;
    logic              adv, stop, at_word0_bit;
    logic              cur_bit;

    assign adv          = (ev == EV_START) && tx_en && cs_en;
    assign stop         = !cs_en || ((ev == EV_SECOND) && !tx_en);
    assign at_word0_bit = (bit_q == '0);
    assign cur_bit      = at_word0_bit ? rd_word[0] : sh_q[0];
    assign rd_idx       = word_q;

    always_ff @(posedge clk) begin
        if (rst || stop) begin
            bit_q  <= '0;
            word_q <= '0;
            sh_q   <= '0;
            c_q    <= 1'b0;
            blk_q  <= 1'b0;
        end else if (adv) begin
            c_q   <= cur_bit;
            blk_q <= at_word0_bit && (word_q == '0);
            sh_q  <= (at_word0_bit ? rd_word : sh_q) >> 1;
            if (bit_q == BIT_LAST) begin
                bit_q  <= '0;
                word_q <= (word_q == WORD_LAST) ? '0 : word_q + 1'b1;
            end else begin
                bit_q <= bit_q + 1'b1;
            end
        end
    end

    always_comb begin
        step.c          = c_q;
        step.blk        = blk_q;
        step.load_first = adv && !stop && at_word0_bit && (word_q == '0);
        step.load_last  = adv && !stop && at_word0_bit && (word_q == WORD_LAST);
    end

endmodule

// File: rtl/cstx_busy.sv
module cstx_busy
    import cstx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  frame_ev_e ev,
    input  logic      tx_en,
    input  logic      cs_en,
    input  logic      load_first,
    input  logic      load_last,
    output logic      cs_busy,
    output logic      tx_busy
);

    logic end_off;
    assign end_off = (ev == EV_SECOND) && !tx_en;

    always_ff @(posedge clk) begin
        if (rst)
            tx_busy <= 1'b0;
        else if (tx_en)
            tx_busy <= 1'b1;
        else if (end_off)
            tx_busy <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst || end_off || !cs_en)
            cs_busy <= 1'b0;
        else if (load_first)
            cs_busy <= 1'b1;
        else if (load_last)
            cs_busy <= 1'b0;
    end

endmodule

// File: rtl/cstx_seq.sv
module cstx_seq
    import cstx_pkg::*;
#(
    parameter int WORD_W = CS_WORD_W,
    parameter int WORDS  = CS_WORDS,
    localparam int WAW   = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_en,
    input  logic              cs_en,
    input  logic              sub_req,
    input  logic              sub_first,
    input  logic              wr_en,
    input  logic [WAW-1:0]    wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    output logic              c_bit,
    output logic              blk_start,
    output logic              cs_busy,
    output logic              tx_busy
);

    frame_ev_e         ev;
    logic [WAW-1:0]    rd_idx;
    logic [WORD_W-1:0] rd_word;
    cs_step_t          step;

    assign ev = ev_decode(sub_req, sub_first);

    cstx_page #(.WORD_W(WORD_W), .WORDS(WORDS)) u_page (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_idx  (rd_idx),
        .rd_word (rd_word)
    );

    cstx_cursor #(.WORD_W(WORD_W), .WORDS(WORDS)) u_cursor (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .tx_en   (tx_en),
        .cs_en   (cs_en),
        .rd_word (rd_word),
        .rd_idx  (rd_idx),
        .step    (step)
    );

    cstx_busy u_busy (
        .clk        (clk),
        .rst        (rst),
        .ev         (ev),
        .tx_en      (tx_en),
        .cs_en      (cs_en),
        .load_first (step.load_first),
        .load_last  (step.load_last),
        .cs_busy    (cs_busy),
        .tx_busy    (tx_busy)
    );

    assign c_bit     = step.c;
    assign blk_start = step.blk;

endmodule

// File: rtl/cstx_seq_chk.sv
module cstx_seq_chk (
    input logic clk,
    input logic rst,
    input logic tx_en,
    input logic cs_en,
    input logic sub_req,
    input logic sub_first,
    input logic c_bit,
    input logic blk_start,
    input logic cs_busy,
    input logic tx_busy
);

    // R7: the status-shift flag never outlives the transmitter flag
    p_cbusy_in_tx_r7: assert property (@(posedge clk) disable iff (rst)
        cs_busy |-> tx_busy);

    // R4: a block-start select only exists while transmitting
    p_blk_in_tx_r4: assert property (@(posedge clk) disable iff (rst)
        blk_start |-> tx_busy);

    // R7: transmitter flag rises only after tx_en was seen
    p_txbusy_rise_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_busy) |-> $past(tx_en));

    // R6: the status-shift flag rises on the first frame of a block
    p_cbusy_rise_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_busy) |-> blk_start);

    // R9: channel-status disable clears outputs one edge later
    p_cs_off_r9: assert property (@(posedge clk) disable iff (rst)
        !cs_en |=> (!c_bit && !blk_start && !cs_busy));

    // R3: second-subframe request keeps the frame's bit
    p_second_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (sub_req && !sub_first && tx_en && cs_en) |=> $stable(c_bit));

endmodule

bind cstx_seq cstx_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .tx_en     (tx_en),
    .cs_en     (cs_en),
    .sub_req   (sub_req),
    .sub_first (sub_first),
    .c_bit     (c_bit),
    .blk_start (blk_start),
    .cs_busy   (cs_busy),
    .tx_busy   (tx_busy)
);

// File: tb/sim_cstx_seq.sv
`timescale 1ns/1ps
module sim_cstx_seq;

    localparam int WW   = 32;
    localparam int NW   = 6;
    localparam int BLK  = WW * NW;
    localparam int CLRF = (NW - 1) * WW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tx_en = 1'b0, cs_en = 1'b0, sub_req = 1'b0, sub_first = 1'b0;
    logic wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic c_bit, blk_start, cs_busy, tx_busy;

    always #5 clk = ~clk;

    cstx_seq u0 (
        .clk(clk), .rst(rst), .tx_en(tx_en), .cs_en(cs_en),
        .sub_req(sub_req), .sub_first(sub_first),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .c_bit(c_bit), .blk_start(blk_start),
        .cs_busy(cs_busy), .tx_busy(tx_busy)
    );

    int vecs = 0;
    int bad = 0;
    bit done = 0;
    logic [31:0] model [NW];
    logic [31:0] snap;
    int pos = 0;
    int blk_no = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual %0h expected %0h (pos %0d)", req, act, exp, pos);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (a < 3'd6) model[a] = d;
    endtask

    // one frame: first subframe, observe, second subframe, observe
    task automatic frame(output logic c1, output logic b1, output logic busy1,
                         output logic c2);
        @(negedge clk);
        sub_req = 1'b1; sub_first = 1'b1;
        @(negedge clk);
        sub_req = 1'b0;
        c1 = c_bit; b1 = blk_start; busy1 = cs_busy;
        @(negedge clk);
        sub_req = 1'b1; sub_first = 1'b0;
        @(negedge clk);
        sub_req = 1'b0;
        c2 = c_bit;
    endtask

    task automatic frame_checked(input string tag);
        logic c1, b1, k1, c2;
        int w, b;
        w = pos / WW;
        b = pos % WW;
        if (b == 0) snap = model[w];
        frame(c1, b1, k1, c2);
        chk(tag, {31'b0, c1}, {31'b0, snap[b]});
        chk("R3 second subframe hold", {31'b0, c2}, {31'b0, snap[b]});
        chk("R4 block start", {31'b0, b1}, {31'b0, pos == 0});
        chk("R6 cs_busy", {31'b0, k1}, {31'b0, pos < CLRF});
        pos = (pos + 1) % BLK;
        if (pos == 0) blk_no++;
    endtask

    initial begin
        logic c1, b1, k1, c2;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk("R10 c_bit", {31'b0, c_bit}, 32'd0);
        chk("R10 blk_start", {31'b0, blk_start}, 32'd0);
        chk("R10 cs_busy", {31'b0, cs_busy}, 32'd0);
        chk("R10 tx_busy", {31'b0, tx_busy}, 32'd0);

        for (int i = 0; i < NW; i++) model[i] = 32'd0;
        // R1: writes beyond the page are dropped (verified via block contents)
        wr(3'd6, 32'hFFFF_FFFF);
        wr(3'd7, 32'hFFFF_FFFF);
        for (int i = 0; i < NW; i++)
            wr(3'(i), 32'h9E37_79B9 * (i + 1) ^ (32'h0F0F_3C3C >> i));

        tx_en = 1'b1; cs_en = 1'b1;
        @(negedge clk);
        chk("R7 tx_busy rise", {31'b0, tx_busy}, 32'd1);

        // R2, R1: two full blocks with wrap; R5 write mid word 1
        pos = 0;
        for (int f = 0; f < 2 * BLK; f++) begin
            if (f == 37) begin
                wr(3'd1, ~model[1]);
                wr(3'd2, model[2] ^ 32'hDEAD_BEEF);
            end
            if (f >= 32 && f < 96)
                frame_checked("R2,R5 page walk");
            else
                frame_checked("R2,R1 page walk");
        end

        // R9: cs_en low mid-block
        for (int f = 0; f < 50; f++) frame_checked("R2 page walk");
        @(negedge clk);
        cs_en = 1'b0;
        @(negedge clk);
        chk("R9 c_bit off", {31'b0, c_bit}, 32'd0);
        chk("R9 cs_busy off", {31'b0, cs_busy}, 32'd0);
        chk("R9 tx_busy kept", {31'b0, tx_busy}, 32'd1);
        for (int f = 0; f < 3; f++) begin
            frame(c1, b1, k1, c2);
            chk("R9 c_bit stays 0", {31'b0, c1}, 32'd0);
            chk("R9 blk_start stays 0", {31'b0, b1}, 32'd0);
        end
        cs_en = 1'b1;
        pos = 0;
        for (int f = 0; f < 40; f++) frame_checked("R9 restart from frame 0");

        // R7: tx_en drops inside a frame
        @(negedge clk);
        sub_req = 1'b1; sub_first = 1'b1;
        @(negedge clk);
        sub_req = 1'b0; tx_en = 1'b0;
        @(negedge clk);
        chk("R7 tx_busy held mid frame", {31'b0, tx_busy}, 32'd1);
        sub_req = 1'b1; sub_first = 1'b0;
        @(negedge clk);
        sub_req = 1'b0;
        chk("R7 tx_busy cleared", {31'b0, tx_busy}, 32'd0);
        chk("R7 cs_busy cleared", {31'b0, cs_busy}, 32'd0);
        chk("R7 c_bit cleared", {31'b0, c_bit}, 32'd0);

        // R8: requests while stopped are ignored
        for (int f = 0; f < 4; f++) begin
            frame(c1, b1, k1, c2);
            chk("R8 c_bit while stopped", {31'b0, c1}, 32'd0);
            chk("R8 blk_start while stopped", {31'b0, b1}, 32'd0);
            chk("R8 tx_busy while stopped", {31'b0, tx_busy}, 32'd0);
        end
        tx_en = 1'b1;
        pos = 0;
        for (int f = 0; f < 70; f++) frame_checked("R8 resume at frame 0");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            vecs++;
            bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
            $finish;
        end
    end

endmodule